// File: doc/BRIEF.md
# Serial Memory Slave Front End with Hold Pause

This block sits at the pin edge of a serial-memory slave that speaks SPI mode 0. It samples the select, serial clock, serial data-in and active-low pause inputs on the system clock. It collects bits MSB first on rising serial-clock edges and hands each completed byte, plus a per-bit strobe, to the command logic behind it. It shifts a transmit byte out, MSB first, changing the output after each falling serial-clock edge. The data-out pin is driven only through an output-enable, so an external pad can tri-state it.

The host can pause a transfer without losing its place by pulling the hold input low while the slave is selected. The pause is aligned to the low phase of the serial clock. If hold changes while the clock is low, the change takes effect at once. If hold changes while the clock is high, the change waits for the clock's next low phase. While paused, the output is released and clock and data-in activity is ignored, so the partial byte is kept. A busy flag from an internal write or erase engine passes through untouched by any pause. If the host deselects during a pause, the interface is cleared and locked out. It will only accept a new selection after hold has been released while deselected.

Top module: `spi_hold_front`

## Requirements
- R1: A pause (`holdActive`=1) can only start while `csN` is low and the interface is not locked out; with `csN` high, a low `holdN` has no effect.
- R2: If `holdN` falls while `sclk` is low, the pause starts within a few system clocks. If `holdN` falls while `sclk` is high, the pause starts only once `sclk` goes low.
- R3: While paused, edges on `sclk` and `mosi` are ignored: no `bitStrobe` pulses, and the bit count and the partial received byte are kept, so the byte completes correctly after the pause.
- R4: If `holdN` rises while `sclk` is low, the pause ends within a few system clocks. If `holdN` rises while `sclk` is high, the pause lasts until `sclk` goes low.
- R5: `misoOe` is 0 while paused, while deselected and while locked out, and 1 otherwise. With it on, `misoOut` carries `txData` MSB first: bit 7 after selection, then the next lower bit after each falling `sclk` edge, wrapping to bit 7 after the eighth.
- R6: `busyOut` follows `busyIn` (one clock later) at all times, including during a pause.
- R7: Raising `csN` during a pause clears the interface and locks it out. A selection made while still locked out (i.e. `holdN` was not high while `csN` was high) starts no pause, accepts no bits and keeps `misoOe` at 0. After `holdN` is high while `csN` is high, the next selection works normally.
- R8: `mosi` is sampled on each rising `sclk` edge, MSB first, and each sample gives one `bitStrobe` pulse. The eighth sample also pulses `byteValid` for one clock, with the byte on `rxByte`.
- R9: Raising `csN` outside a pause discards any partial byte; the next selection starts a fresh byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host (idles low) |
| mosi | input | 1 | Serial data from the host |
| holdN | input | 1 | Active-low pause request |
| busyIn | input | 1 | Busy flag of the internal write/erase engine |
| txData | input | DATA_W | Byte to shift out to the host |
| misoOut | output | 1 | Serial data towards the host |
| misoOe | output | 1 | Output enable for the data-out pad |
| rxByte | output | DATA_W | Last completed received byte |
| byteValid | output | 1 | One-clock pulse when a byte completes |
| bitStrobe | output | 1 | One-clock pulse per accepted bit |
| holdActive | output | 1 | Pause in effect |
| busyOut | output | 1 | Busy flag seen by the host side |

## Verification
A pause flag that starts or ends in the wrong serial-clock phase shows up as a `misoOe` value that is wrong at the next sampling point. It also shows up as an extra or missing `bitStrobe` on the first clock edge after the hold change. A bit counter that moved during a pause, or a partial byte kept across a deselect, shows up as a wrong `rxByte` at the next `byteValid`, within eight serial clocks. A lockout that fails to engage or clear shows up on the first selection after it: bits are accepted or refused against expectation, and the driver is enabled or not.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

  // Strobes from the control to the datapath, one per system clock.
  typedef struct packed {
    logic clear;     // interface idle or reset: drop partial state, reload tx
    logic shiftIn;   // accept one data-in bit
    logic shiftOut;  // advance the transmit bit
  } dpCtl_t;

endpackage

// File: rtl/spi_hold_ctl.sv
module spi_hold_ctl
  import spi_hold_pkg::*;
#(
  parameter int IN_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   csN,
  input  logic   sclk,
  input  logic   mosi,
  input  logic   holdN,
  input  logic   busyIn,
  output dpCtl_t ctl,
  output logic   mosiQ,
  output logic   paused,
  output logic   locked,
  output logic   oe,
  output logic   busyOut
);

  localparam int LastStage = IN_STAGES - 1;

  logic [LastStage:0] csS, sclkS, mosiS, holdS;
  logic csQ, sclkQ, holdQ, sclkPrev;
  logic sclkRise, sclkFall, active;

  // Input alignment stages (IN_STAGES must be 2 or more).
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csS   <= '1;
      sclkS <= '0;
      mosiS <= '0;
      holdS <= '1;
    end else begin
      csS   <= {csS[LastStage-1:0], csN};
      sclkS <= {sclkS[LastStage-1:0], sclk};
      mosiS <= {mosiS[LastStage-1:0], mosi};
      holdS <= {holdS[LastStage-1:0], holdN};
    end
  end

  assign csQ   = csS[LastStage];
  assign sclkQ = sclkS[LastStage];
  assign mosiQ = mosiS[LastStage];
  assign holdQ = holdS[LastStage];

  // Pause and lockout state.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      paused   <= 1'b0;
      locked   <= 1'b0;
      sclkPrev <= 1'b0;
      busyOut  <= 1'b0;
    end else begin
      sclkPrev <= sclkQ;
      busyOut  <= busyIn;
      if (csQ) begin
        if (paused)     locked <= 1'b1;
        else if (holdQ) locked <= 1'b0;
        paused <= 1'b0;
      end else if (!locked) begin
        if (!paused && !holdQ && !sclkQ)     paused <= 1'b1;
        else if (paused && holdQ && !sclkQ)  paused <= 1'b0;
      end
    end
  end

  assign sclkRise = sclkQ & ~sclkPrev;
  assign sclkFall = ~sclkQ & sclkPrev;
  assign active   = ~csQ & ~locked;

  always_comb begin
    ctl.clear    = ~active;
    ctl.shiftIn  = active & ~paused & sclkRise;
    ctl.shiftOut = active & ~paused & sclkFall;
    oe           = active & ~paused;
  end

  // R1 / R2: a pause starts only while selected and with the clock low.
  p_select_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(paused) |-> $past(!csQ && !locked));
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(paused) |-> $past(!sclkQ && !holdQ));
  // R4: a pause ends only with the clock low or on deselection.
  p_end_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(paused) |-> $past(csQ || (!sclkQ && holdQ)));
  // R7: lockout and pause never coexist.
  p_lock_nopause_r7: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> !paused);

endmodule

// File: rtl/spi_hold_dp.sv
module spi_hold_dp
  import spi_hold_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              mosiQ,
  input  logic [DATA_W-1:0] txData,
  input  logic              pausedIn,
  input  logic              lockedIn,
  output logic [DATA_W-1:0] rxByte,
  output logic              byteValid,
  output logic              bitStrobe,
  output logic              misoBit
);

  localparam int CntW = $clog2(DATA_W);
  localparam logic [CntW-1:0] LastBit = CntW'(DATA_W - 1);

  logic [CntW-1:0]   bitCnt;
  logic [DATA_W-1:0] shReg, txReg;
  logic [DATA_W-1:0] nextSh;

  assign nextSh = {shReg[DATA_W-2:0], mosiQ};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      shReg     <= '0;
      txReg     <= '0;
      rxByte    <= '0;
      byteValid <= 1'b0;
      bitStrobe <= 1'b0;
    end else begin
      byteValid <= 1'b0;
      bitStrobe <= 1'b0;
      if (ctl.clear) begin
        bitCnt <= '0;
        shReg  <= '0;
        txReg  <= txData;
      end else begin
        if (ctl.shiftIn) begin
          bitStrobe <= 1'b1;
          shReg     <= nextSh;
          if (bitCnt == LastBit) begin
            bitCnt    <= '0;
            byteValid <= 1'b1;
            rxByte    <= nextSh;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        if (ctl.shiftOut) begin
          if (bitCnt == '0) txReg <= txData;
          else              txReg <= {txReg[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign misoBit = txReg[DATA_W-1];

  // R3: receive state frozen across a pause.
  p_frozen_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pausedIn && !ctl.clear) |=> ($stable(bitCnt) && $stable(shReg)));
  // R7: a locked-out interface holds no partial byte.
  p_lock_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    lockedIn |-> (bitCnt == '0));
  // R8: a completed byte is always the result of an accepted bit.
  p_byte_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> bitStrobe);
  // R9: deselection drops the partial byte.
  p_deselect_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> (bitCnt == '0 && !byteValid));

endmodule

// File: rtl/spi_hold_front.sv
module spi_hold_front
  import spi_hold_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int IN_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              holdN,
  input  logic              busyIn,
  input  logic [DATA_W-1:0] txData,
  output logic              misoOut,
  output logic              misoOe,
  output logic [DATA_W-1:0] rxByte,
  output logic              byteValid,
  output logic              bitStrobe,
  output logic              holdActive,
  output logic              busyOut
);

  dpCtl_t ctlStrobes;
  logic   mosiQ, paused, locked, oe, misoBit;

  spi_hold_ctl #(.IN_STAGES(IN_STAGES)) u_ctl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi),
    .holdN(holdN), .busyIn(busyIn), .ctl(ctlStrobes), .mosiQ(mosiQ),
    .paused(paused), .locked(locked), .oe(oe), .busyOut(busyOut)
  );

  spi_hold_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctlStrobes), .mosiQ(mosiQ),
    .txData(txData), .pausedIn(paused), .lockedIn(locked),
    .rxByte(rxByte), .byteValid(byteValid), .bitStrobe(bitStrobe),
    .misoBit(misoBit)
  );

  assign misoOut    = misoBit;
  assign misoOe     = oe;
  assign holdActive = paused;

  // R5: every accepted bit was taken while the driver was on.
  p_accept_driven_r5: assert property (@(posedge clk) disable iff (!rstN)
    bitStrobe |-> $past(misoOe));

endmodule

// File: tb/spi_hold_front_tb.sv
module spi_hold_front_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1, sclk = 1'b0, mosi = 1'b0, holdN = 1'b1, busyIn = 1'b0;
  logic [7:0] txData = 8'h00;
  logic       misoOut, misoOe, byteValid, bitStrobe, holdActive, busyOut;
  logic [7:0] rxByte;

  int checks = 0, fails = 0, strobeCnt = 0;
  bit done = 0;
  logic [7:0] expQ[$];

  always #4 clk = ~clk;  // 125 MHz

  spi_hold_front u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi),
    .holdN(holdN), .busyIn(busyIn), .txData(txData), .misoOut(misoOut),
    .misoOe(misoOe), .rxByte(rxByte), .byteValid(byteValid),
    .bitStrobe(bitStrobe), .holdActive(holdActive), .busyOut(busyOut)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Monitor: compares completed bytes against the scoreboard queue.
  always @(negedge clk) begin
    if (bitStrobe) strobeCnt++;
    if (byteValid) begin
      if (expQ.size() == 0) chk(1'b0, "R8 unexpected byte", rxByte, 0);
      else begin
        logic [7:0] e;
        e = expQ.pop_front();
        chk(rxByte == e, "R8 received byte", rxByte, e);
      end
    end
  end

  // Driver: n bits of v MSB first; checks the outgoing bit before each rise.
  task automatic sendBits(input logic [7:0] v, input int n, input int startIdx, input bit chkMiso);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = v[i];
      waitClk(3);
      if (chkMiso) begin
        int idx;
        idx = 7 - ((startIdx + (n - 1 - i)) % 8);
        chk(misoOe && misoOut == txData[idx], "R5 output bit", {misoOe, misoOut}, {1'b1, txData[idx]});
      end
      sclk = 1'b1; waitClk(6);
      sclk = 1'b0; waitClk(6);
    end
  endtask

  task automatic pushByte(input logic [7:0] v);
    expQ.push_back(v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int s0;
    waitClk(3);
    rstN = 1'b1;
    waitClk(4);
    chk(!misoOe && !byteValid && !holdActive && !busyOut, "R5 reset state",
        {misoOe, byteValid, holdActive, busyOut}, 0);

    // R1: hold while deselected does nothing.
    holdN = 1'b0; waitClk(8);
    chk(!holdActive, "R1 hold while deselected", holdActive, 0);
    holdN = 1'b1; waitClk(6);

    // R8: plain bytes.
    txData = 8'hA5;
    csN = 1'b0; waitClk(6);
    chk(misoOe && misoOut == 1'b1, "R5 MSB after select", {misoOe, misoOut}, 2'b11);
    pushByte(8'h3C); sendBits(8'h3C, 8, 0, 1);
    pushByte(8'hC3); sendBits(8'hC3, 8, 8, 1);
    waitClk(4);
    chk(strobeCnt == 16, "R8 bit strobes", strobeCnt, 16);
    csN = 1'b1; waitClk(6);
    chk(!misoOe, "R5 released when deselected", misoOe, 0);

    // R2/R3/R4: hold edges with the clock low.
    txData = 8'h69;
    csN = 1'b0; waitClk(6);
    pushByte(8'h96); sendBits(8'h9, 4, 0, 1);
    holdN = 1'b0; waitClk(6);
    chk(holdActive, "R2 pause with clock low", holdActive, 1);
    chk(!misoOe, "R5 high impedance in pause", misoOe, 0);
    busyIn = 1'b1; waitClk(3);
    chk(busyOut, "R6 busy during pause", busyOut, 1);
    s0 = strobeCnt;
    for (int k = 0; k < 4; k++) begin
      mosi = k[0]; sclk = 1'b1; waitClk(6);
      chk(!misoOe, "R5 high impedance in pause", misoOe, 0);
      sclk = 1'b0; waitClk(6);
    end
    chk(strobeCnt == s0, "R3 no bits taken in pause", strobeCnt, s0);
    busyIn = 1'b0; waitClk(3);
    chk(!busyOut, "R6 busy clear during pause", busyOut, 0);
    holdN = 1'b1; waitClk(6);
    chk(!holdActive && misoOe, "R4 resume with clock low", {holdActive, misoOe}, 2'b01);
    sendBits(8'h6, 4, 4, 1);
    csN = 1'b1; waitClk(6);

    // R2/R4: hold edges with the clock high (deferred).
    txData = 8'hB4;
    csN = 1'b0; waitClk(6);
    pushByte(8'h5A); sendBits(8'h2, 3, 0, 1);
    mosi = 1'b1; waitClk(3);
    sclk = 1'b1; waitClk(6);
    holdN = 1'b0; waitClk(6);
    chk(!holdActive && misoOe, "R2 pause deferred while clock high", {holdActive, misoOe}, 2'b01);
    sclk = 1'b0; waitClk(6);
    chk(holdActive && !misoOe, "R2 pause at clock low", {holdActive, misoOe}, 2'b10);
    s0 = strobeCnt;
    sclk = 1'b1; waitClk(6);
    holdN = 1'b1; waitClk(6);
    chk(holdActive && !misoOe, "R4 resume deferred while clock high", {holdActive, misoOe}, 2'b10);
    chk(strobeCnt == s0, "R3 rise in pause ignored", strobeCnt, s0);
    sclk = 1'b0; waitClk(6);
    chk(!holdActive && misoOe, "R4 resume at clock low", {holdActive, misoOe}, 2'b01);
    sendBits(8'hA, 4, 4, 1);
    csN = 1'b1; waitClk(6);

    // R7: deselect during pause, restart with hold still low is refused.
    txData = 8'hF0;
    csN = 1'b0; waitClk(6);
    sendBits(8'h3, 2, 0, 0);
    holdN = 1'b0; waitClk(6);
    csN = 1'b1; waitClk(6);
    chk(!holdActive && !misoOe, "R7 reset on deselect in pause", {holdActive, misoOe}, 0);
    csN = 1'b0; waitClk(6);
    chk(!holdActive && !misoOe, "R7 no pause re-entry when locked", {holdActive, misoOe}, 0);
    s0 = strobeCnt;
    sendBits(8'hFF, 8, 0, 0);
    chk(strobeCnt == s0, "R7 no bits while locked", strobeCnt, s0);
    holdN = 1'b1; waitClk(6);
    chk(!misoOe, "R7 still locked until deselected", misoOe, 0);
    csN = 1'b1; waitClk(6);
    csN = 1'b0; waitClk(6);
    chk(misoOe && misoOut == 1'b1, "R7 restart after hold released", {misoOe, misoOut}, 2'b11);
    pushByte(8'h81); sendBits(8'h81, 8, 0, 1);
    csN = 1'b1; waitClk(6);

    // R9: partial byte discarded on deselect.
    txData = 8'h0F;
    csN = 1'b0; waitClk(6);
    sendBits(8'h15, 5, 0, 0);
    csN = 1'b1; waitClk(6);
    csN = 1'b0; waitClk(6);
    pushByte(8'h7E); sendBits(8'h7E, 8, 0, 1);
    csN = 1'b1; waitClk(10);
    chk(expQ.size() == 0, "R9 all expected bytes seen", expQ.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule